// File: doc/BRIEF.md
# 3x3 Sliding Window Generator

This block turns a raster-ordered stream of pixels from one square feature-map plane into the complete set of 3x3 neighbourhoods it contains, one neighbourhood per output beat. Each output beat is a 72-bit word of nine bytes. A convolution engine downstream can then consume one full kernel footprint per handshake, and it never has to fetch overlapping pixels twice from memory.

The only storage is one delay line of 2*COLS+3 samples. New pixels enter at position 0, and all nine window taps are read straight from fixed delay-line positions, so no full-frame buffer is needed. A column counter and a row counter follow the raster position. A window is produced only once both counters show that a full 3x3 footprint has arrived. A start-of-plane flag on the first pixel forces both counters back to the origin, so a plane that is replayed once per output filter, or cut short, always restarts cleanly. Both sides use valid/ready. Input acceptance stalls while a window is waiting, so no window is dropped or repeated.

Top module: `win3_top`

## Requirements
- R1: While `rstN` is low and on the cycle after it rises, `outValid` is 0 and `inReady` is 1.
- R2: Byte `3*i+j` of `outWin` (bits `8*(3*i+j)+7 : 8*(3*i+j)`) holds the pixel at row `r-2+i`, column `c-2+j`. Here `(r,c)` is the raster position of the pixel that completed the window: `i=0` is the top row and `j=0` is the left column.
- R3: A window is produced for an accepted pixel exactly when its column is at least 2 and its row is at least 2. This gives (COLS-2)*(ROWS-2) windows per full plane, delivered in raster order.
- R4: The window completed by an accepted pixel is presented on `outValid`/`outWin` in the cycle after that pixel is accepted.
- R5: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and `outWin` stays stable. No window is lost or duplicated.
- R6: A pixel accepted with `inSop=1` takes position row 0, column 0, even in the middle of a plane. No window ever mixes pixels from before and after that pixel.
- R7: Without `inSop`, the position wraps from (ROWS-1, COLS-1) to (0, 0), and the following plane is windowed as a fresh plane.
- R8: A cycle with `inValid=0` does not change the position or the delay line, and it produces no window, whatever `inData` and `inSop` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Block can take a pixel this cycle |
| inData | input | PIX_W | Pixel value |
| inSop | input | 1 | Pixel is the first of a plane |
| outValid | output | 1 | Window available |
| outReady | input | 1 | Consumer takes the window this cycle |
| outWin | output | 9*PIX_W | Nine-byte window, byte 3*i+j = row i, column j |

## Verification
The bench runs a 6x5 plane through every window position. It compares each window byte by byte against values computed from the pixel index, so a tap at the wrong delay-line offset or a swapped byte order shows up as a value mismatch. It goes after the row and column gating edges, a plane that ends without a fresh start flag, and a truncated plane followed by a new start flag. A design that gated windows badly, or that forgot to reset or wrap its counters, would emit windows from the wrong rows or mixed planes, and the per-plane window counts would differ. Random backpressure and input gaps with garbage on the data and start lines catch a design that shifts while stalled or during idle cycles. Such a design would drop, repeat or corrupt windows.

// File: rtl/win3_pkg.sv
package win3_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // accept a pixel into the delay line
    logic markWin;  // the accepted pixel completes a window
  } win3_strb_t;
endpackage

// File: rtl/win3_ctrl.sv
module win3_ctrl
  import win3_pkg::*;
#(
  parameter int COLS = 15,
  parameter int ROWS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSop,
  input  logic       outValid,
  input  logic       outReady,
  output logic       inReady,
  output win3_strb_t strb
);
  localparam int CW = (COLS > 2) ? $clog2(COLS) : 2;
  localparam int RW = (ROWS > 2) ? $clog2(ROWS) : 2;
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  logic [CW-1:0] colCnt, colPos;
  logic [RW-1:0] rowCnt, rowPos;
  logic          accept, lastCol, lastRow;

  // Position of the pixel on the input; start-of-plane forces the origin
  always_comb begin
    colPos  = inSop ? '0 : colCnt;
    rowPos  = inSop ? '0 : rowCnt;
    lastCol = (colPos == COL_LAST);
    lastRow = (rowPos == ROW_LAST);
    inReady = !outValid || outReady;
    accept  = inValid && inReady;
    strb.shiftEn = accept;
    strb.markWin = accept && (colPos >= CW'(2)) && (rowPos >= RW'(2));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (accept) begin
      colCnt <= lastCol ? '0 : colPos + CW'(1);
      if (lastCol) rowCnt <= lastRow ? '0 : rowPos + RW'(1);
      else         rowCnt <= rowPos;
    end
  end
endmodule

// File: rtl/win3_dpath.sv
module win3_dpath
  import win3_pkg::*;
#(
  parameter int COLS  = 15,
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  win3_strb_t         strb,
  input  logic [PIX_W-1:0]   inData,
  input  logic               outReady,
  output logic               outValid,
  output logic [9*PIX_W-1:0] outWin
);
  localparam int DEPTH = 2 * COLS + 3;

  // Position 0 holds the newest pixel
  logic [PIX_W-1:0] delayLine [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.shiftEn) begin
      delayLine[0] <= inData;
      for (int k = 1; k < DEPTH; k++) delayLine[k] <= delayLine[k-1];
    end
  end

  // Window taps: top-left is the oldest tap, bottom-right the newest
  for (genvar i = 0; i < 3; i++) begin : g_row
    for (genvar j = 0; j < 3; j++) begin : g_col
      localparam int TAP = (2 - i) * COLS + (2 - j);
      assign outWin[(3*i+j)*PIX_W +: PIX_W] = delayLine[TAP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outValid <= 1'b0;
    else if (strb.markWin) outValid <= 1'b1;
    else if (outReady)     outValid <= 1'b0;
  end
endmodule

// File: rtl/win3_top.sv
module win3_top
  import win3_pkg::*;
#(
  parameter int COLS  = 15,
  parameter int ROWS  = 15,
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [PIX_W-1:0]   inData,
  input  logic               inSop,
  output logic               outValid,
  input  logic               outReady,
  output logic [9*PIX_W-1:0] outWin
);
  win3_strb_t strb;

  win3_ctrl #(.COLS(COLS), .ROWS(ROWS)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop),
    .outValid(outValid), .outReady(outReady), .inReady(inReady), .strb(strb)
  );

  win3_dpath #(.COLS(COLS), .PIX_W(PIX_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .outReady(outReady), .outValid(outValid), .outWin(outWin)
  );
endmodule

// File: rtl/win3_chk.sv
module win3_chk #(
  parameter int WIN_W = 72
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inSop,
  input logic             outValid,
  input logic             outReady,
  input logic [WIN_W-1:0] outWin
);
  // R1: reset leaves no window pending
  a_r1_reset_idle: assert property (@(posedge clk) !rstN |=> !outValid);

  // R5: a pending window blocks input
  a_r5_stall_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R5: a pending window is held unchanged
  a_r5_hold_window: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWin)));

  // R8: no accepted pixel, no new window
  a_r8_no_window_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!(inValid && inReady) && outReady) |=> !outValid);

  // R6: a start-of-plane pixel is at the origin and never completes a window
  a_r6_sop_no_window: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inSop) |=> !outValid);
endmodule

bind win3_top win3_chk #(.WIN_W(9*PIX_W)) i_win3_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSop(inSop),
  .outValid(outValid), .outReady(outReady), .outWin(outWin)
);

// File: tb/test_win3_top.sv
module test_win3_top;
  localparam int COLS = 6;
  localparam int ROWS = 5;
  localparam int PW   = 8;
  localparam int NSEG = 5;

  logic          clk = 1'b0;
  logic          rstN, inValid, inReady, inSop, outValid, outReady;
  logic [PW-1:0] inData;
  logic [71:0]   outWin;

  always #2 clk = ~clk;

  win3_top #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PW)) i_win3_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSop(inSop), .outValid(outValid), .outReady(outReady), .outWin(outWin)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Segment plan: length, mode (0 steady, 1 backpressure, 2 backpressure and gaps)
  int segLen  [NSEG] = '{COLS*ROWS, 2*COLS*ROWS, 2*COLS+4, COLS*ROWS, COLS*ROWS};
  int segMode [NSEG] = '{0, 1, 2, 1, 2};
  string segReq [NSEG] = '{"R3", "R7", "R6", "R6", "R3"};

  function automatic logic [7:0] pixVal(int seg, int n);
    return 8'((seg * 53 + n * 7 + (n >> 3)) & 255);
  endfunction

  function automatic bit isWin(int n);
    int r, c;
    r = (n / COLS) % ROWS;
    c = n % COLS;
    return (r >= 2) && (c >= 2);
  endfunction

  function automatic logic [71:0] expWin(int seg, int n);
    logic [71:0] w;
    w = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        w[(3*i+j)*8 +: 8] = pixVal(seg, n - (2 - i) * COLS - (2 - j));
    return w;
  endfunction

  logic [71:0] expQ[$];
  int          expSegQ[$];
  int          expCnt [NSEG];
  int          gotCnt [NSEG];

  initial begin
    int seg, n, mode, prevN, prevMode, cyc, drain, s;
    bit prevAccept, prevHold, prevOutReady, done;
    logic [71:0] savedWin, ew;

    for (int k = 0; k < NSEG; k++) begin
      expCnt[k] = 0;
      gotCnt[k] = 0;
      for (int m = 0; m < segLen[k]; m++)
        if (isWin(m)) begin
          expQ.push_back(expWin(k, m));
          expSegQ.push_back(k);
          expCnt[k]++;
        end
    end

    rstN = 1'b0; inValid = 1'b0; inSop = 1'b0; inData = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", 72'(outValid), 72'(0));
    check(inReady == 1'b1, "R1 inReady in reset", 72'(inReady), 72'(1));
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", 72'(outValid), 72'(0));

    seg = 0; n = 0; prevN = 0; prevMode = 1; cyc = 0; drain = 0; done = 1'b0;
    prevAccept = 1'b0; prevHold = 1'b0; prevOutReady = 1'b0; savedWin = '0;

    while (!done) begin
      @(negedge clk);
      cyc++;
      // Results of the previous edge
      if (prevAccept && prevMode == 0)
        check(outValid == isWin(prevN), "R4 window one cycle after pixel",
              72'(outValid), 72'(isWin(prevN)));
      if (prevHold)
        check(outValid && outWin == savedWin, "R5 held window", outWin, savedWin);
      if (!prevAccept && prevOutReady)
        check(outValid == 1'b0, "R8 no window without input", 72'(outValid), 72'(0));

      // New stimulus
      mode = (seg < NSEG) ? segMode[seg] : 0;
      outReady = (mode == 0) ? 1'b1 : (($urandom % 4) != 0);
      if (seg < NSEG) inValid = (mode == 2) ? (($urandom % 3) != 0) : 1'b1;
      else            inValid = 1'b0;
      if (inValid) begin
        inData = pixVal(seg, n);
        inSop  = (n == 0);
      end else begin
        inData = 8'($urandom);
        inSop  = 1'($urandom);
      end
      #1;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 surplus window", outWin, 72'(0));
        end else begin
          ew = expQ.pop_front();
          s  = expSegQ.pop_front();
          gotCnt[s]++;
          check(outWin == ew, "R2 window contents", outWin, ew);
        end
      end
      prevHold = outValid && !outReady;
      if (prevHold) begin
        check(inReady == 1'b0, "R5 input stalled", 72'(inReady), 72'(0));
        savedWin = outWin;
      end
      prevAccept   = inValid && inReady;
      prevN        = n;
      prevMode     = mode;
      prevOutReady = outReady;
      if (prevAccept) begin
        n++;
        if (n == segLen[seg]) begin
          seg++;
          n = 0;
        end
      end
      if (seg == NSEG) drain++;
      if (drain > 20) done = 1'b1;
      if (cyc > 20000) begin
        check(1'b0, "watchdog expired", 72'(cyc), 72'(20000));
        done = 1'b1;
      end
    end

    check(expQ.size() == 0, "R3 all windows delivered", 72'(expQ.size()), 72'(0));
    for (int k = 0; k < NSEG; k++)
      check(gotCnt[k] == expCnt[k], segReq[k], 72'(gotCnt[k]), 72'(expCnt[k]));
    check(expCnt[0] == (COLS-2)*(ROWS-2), "R3 windows per plane",
          72'(expCnt[0]), 72'((COLS-2)*(ROWS-2)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule